// File: doc/BRIEF.md
# Pipelined Initializable Control-Store ROM

This block is a read-only lookup table of 1024 eight-bit words with a pipeline register on its output. It is meant as a microprogram control store. At each rising clock edge the word at the presented address is captured into the output register. The register then holds that word while the next address is decoded, so fetching the next word overlaps with executing the current one.

The output has two active-low gates. The first is sampled by the clock. The second acts at once, with no clock involved. An extra programmable word, separate from the 1024-word array, can be forced into the output register by an active-low initialize input. That word might be a reset or interrupt microinstruction. A parameter selects how initialize works:
- It can load the word straight into the output stage, independent of the clock.
- It can take part only at the next capture edge.

The array and the extra word are filled through a simple synchronous write port before use. The three-state outputs of a discrete part are represented here by a data bus plus a flag that says whether the bus is driven.

Top module: `irom_pipe`

## Requirements
- R1: The array holds 1024 words of 8 bits, selected by the 10-bit `rd_addr`. The word addressed at a rising edge appears on `q_data` after that edge, provided no initialize is in effect and both enables allow output.
- R2: A change of `rd_addr` between two rising edges leaves `q_data` unchanged until the next rising edge.
- R3: `sen_n` is active low and is captured at each rising edge. If it was captured high, `q_valid` is low from that edge on, whatever `aen_n` is. The data register still loads at every edge, so the edge that captures `sen_n` low shows the word addressed at that edge.
- R4: `aen_n` is active low and combinational. While it is high, `q_valid` is low. Its effect does not wait for a clock edge.
- R5: While `rst_n` is low, and through the second rising edge after its release, the captured enable stays set and `q_valid` is low.
- R6: The initialize word is fully programmable. A value of 8'h00 makes initialize act as a clear, and 8'hFF makes it act as a preset.
- R7: When `MODE` is `INIT_ASYNC`:
  - A low on `init_n` loads the initialize word into the output register at once, with no clock edge.
  - The word stays there after `init_n` rises, until the next rising edge.
  - A low held across a rising edge keeps the register at the initialize word.
- R8: When `MODE` is `INIT_SYNC`:
  - `init_n` is captured at the rising edge. A low there takes priority over the addressed word.
  - A low pulse that falls and rises between two edges has no effect on the outputs.
- R9: A write with `cfg_we` high is stored at the rising edge.
  - If `cfg_idx[10]` is 0, the write goes to array word `cfg_idx[9:0]`.
  - If `cfg_idx[10]` is 1 (index 1024), the write goes to the initialize word.
  - Stored words read back through the normal read path.
- R10: `q_valid` is high exactly when the captured `sen_n` was low and `aen_n` is low. Whenever `q_valid` is low, `q_data` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 11 | Write index; bit 10 selects the initialize word |
| cfg_data | input | 8 | Configuration write data |
| rd_addr | input | 10 | Read address |
| sen_n | input | 1 | Clocked output enable, active low |
| aen_n | input | 1 | Immediate output enable, active low |
| init_n | input | 1 | Initialize, active low |
| q_data | output | 8 | Registered data, zero when not driven |
| q_valid | output | 1 | High when the data bus is driven |

## Verification
The bench builds two instances at the default 10-bit address and 8-bit width, one with `INIT_ASYNC` and one with `INIT_SYNC`, and drives both with identical stimulus. A single initialize pulse between edges therefore shows both behaviours at once: the immediate load in one instance and the ignored pulse in the other. Held initialize, clear and preset values, enable interplay and the release of the reset synchronizer are each checked at the exact edge or mid-cycle instant at which the requirements fix the outcome.

// File: rtl/irom_pkg.sv
package irom_pkg;
  typedef enum logic {
    INIT_ASYNC = 1'b0,
    INIT_SYNC  = 1'b1
  } init_mode_e;
endpackage

// File: rtl/irom_rst_sync.sv
module irom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/irom_store.sv
module irom_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/irom_init_reg.sv
module irom_init_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] word_q
);
  logic [DATA_W-1:0] word_d;

  always_comb word_d = wr_en ? wr_data : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/irom_out_stage.sv
module irom_out_stage
  import irom_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter init_mode_e MODE   = INIT_ASYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_n,
  input  logic [DATA_W-1:0] init_word,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] data_q
);
  generate
    if (MODE == INIT_ASYNC) begin : g_async
      // initialize loads the output stage directly, outside the clock
      always_ff @(posedge clk or negedge rst_n or negedge init_n) begin
        if (!rst_n)       data_q <= '0;
        else if (!init_n) data_q <= init_word;
        else              data_q <= rd_word;
      end
    end else begin : g_sync
      // initialize only steers the pre-capture value
      logic [DATA_W-1:0] master_d;
      always_comb master_d = init_n ? rd_word : init_word;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= master_d;
      end
    end
  endgenerate
endmodule

// File: rtl/irom_pipe.sv
module irom_pipe
  import irom_pkg::*;
#(
  parameter int         ADDR_W     = 10,
  parameter int         DATA_W     = 8,
  parameter init_mode_e MODE       = INIT_ASYNC,
  parameter int         RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W:0]   cfg_idx,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              sen_n,
  input  logic              aen_n,
  input  logic              init_n,
  output logic [DATA_W-1:0] q_data,
  output logic              q_valid
);
  localparam int IDX_W = ADDR_W + 1;

  logic              rst_int_n;
  logic              sel_init;
  logic              array_we;
  logic              init_we;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] init_word;
  logic [DATA_W-1:0] data_q;
  logic              sen_q;
  logic              sen_d;

  irom_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  always_comb begin
    sel_init = cfg_idx[IDX_W-1];
    array_we = cfg_we & ~sel_init;
    init_we  = cfg_we &  sel_init;
  end

  irom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (array_we),
    .wr_addr (cfg_idx[ADDR_W-1:0]),
    .wr_data (cfg_data),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  irom_init_reg #(.DATA_W(DATA_W)) u_init (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (init_we),
    .wr_data (cfg_data),
    .word_q  (init_word)
  );

  irom_out_stage #(.DATA_W(DATA_W), .MODE(MODE)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .init_n    (init_n),
    .init_word (init_word),
    .rd_word   (rd_word),
    .data_q    (data_q)
  );

  // clocked enable: comes out of reset set, so the outputs start off
  always_comb sen_d = sen_n;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sen_q <= 1'b1;
    else            sen_q <= sen_d;
  end

  always_comb begin
    q_valid = ~sen_q & ~aen_n;
    q_data  = q_valid ? data_q : '0;
  end
endmodule

// File: rtl/irom_checker.sv
module irom_checker
  import irom_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter init_mode_e MODE   = INIT_ASYNC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_int_n,
  input logic              cfg_we,
  input logic              sen_n,
  input logic              aen_n,
  input logic              init_n,
  input logic [DATA_W-1:0] init_word,
  input logic [DATA_W-1:0] rd_word,
  input logic [DATA_W-1:0] q_data,
  input logic              q_valid
);
  logic armed;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) armed <= 1'b0;
    else            armed <= 1'b1;
  end

  assert_off_data_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> (q_data == '0));

  assert_aen_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    aen_n |-> !q_valid);

  assert_sen_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n |=> !q_valid);

  always @(negedge clk) begin
    if (!rst_n) assert_reset_off_R5: assert (!q_valid);
  end

  generate
    if (MODE == INIT_ASYNC) begin : g_async_chk
      assert_async_init_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
        (armed && !init_n && q_valid && !$past(cfg_we)) |-> (q_data == init_word));
    end else begin : g_sync_chk
      assert_sync_init_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
        (armed && !$past(init_n) && !$past(cfg_we) && q_valid) |-> (q_data == init_word));
      assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
        (armed && $past(init_n) && q_valid) |-> (q_data == $past(rd_word)));
    end
  endgenerate
endmodule

bind irom_pipe irom_checker #(.DATA_W(DATA_W), .MODE(MODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_int_n),
  .cfg_we    (cfg_we),
  .sen_n     (sen_n),
  .aen_n     (aen_n),
  .init_n    (init_n),
  .init_word (init_word),
  .rd_word   (rd_word),
  .q_data    (q_data),
  .q_valid   (q_valid)
);

// File: tb/tb_irom_pipe.sv
`timescale 1ns/1ps
module tb_irom_pipe;
  import irom_pkg::*;

  localparam logic [7:0] INITW = 8'hC3;
  localparam int NROWS = 12;
  // row: {addr[9:0], sen_n, aen_n, init_n, exp_valid, exp_is_init}
  localparam logic [14:0] VEC [NROWS] = '{
    {10'h000, 5'b00110}, {10'h3FF, 5'b00110}, {10'h155, 5'b01100},
    {10'h2AA, 5'b10100}, {10'h0F0, 5'b00110}, {10'h123, 5'b00011},
    {10'h124, 5'b00110}, {10'h200, 5'b11100}, {10'h201, 5'b00110},
    {10'h0FF, 5'b00110}, {10'h3FE, 5'b00011}, {10'h001, 5'b00110}
  };

  logic       clk = 1'b0;
  logic       rst_n, cfg_we, sen_n, aen_n, init_n;
  logic [10:0] cfg_idx;
  logic [7:0] cfg_data;
  logic [9:0] rd_addr;
  logic [7:0] qa_data, qs_data;
  logic       qa_valid, qs_valid;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irom_pipe #(.MODE(INIT_ASYNC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rd_addr(rd_addr), .sen_n(sen_n), .aen_n(aen_n), .init_n(init_n),
    .q_data(qa_data), .q_valid(qa_valid)
  );

  irom_pipe #(.MODE(INIT_SYNC)) dut_sync (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rd_addr(rd_addr), .sen_n(sen_n), .aen_n(aen_n), .init_n(init_n),
    .q_data(qs_data), .q_valid(qs_valid)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) ^ (a >> 3) ^ 8'h5A);
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input int idx, input logic [7:0] d);
    cfg_we = 1'b1; cfg_idx = 11'(idx); cfg_data = d;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
    rd_addr = '0; sen_n = 1'b0; aen_n = 1'b0; init_n = 1'b1;
    repeat (3) step();
    // R5: outputs off in reset
    chk1("R5 reset valid async", qa_valid, 1'b0);
    chk1("R5 reset valid sync", qs_valid, 1'b0);
    chk8("R5/R10 reset data", qa_data, 8'h00);
    rst_n = 1'b1;
    #1 chk1("R5 just released", qa_valid, 1'b0);
    step(); chk1("R5 edge 1 after release", qa_valid, 1'b0);
    step(); chk1("R5 edge 2 after release", qs_valid, 1'b0);
    step(); chk1("R5 edge 3 after release", qa_valid, 1'b1);

    // R9: program array and initialize word
    for (int i = 0; i < 1024; i++) cfg_write(i, pat(i));
    cfg_write(1024, INITW);

    // table: R1/R3/R4/R10 and held initialize (R7/R8)
    for (int r = 0; r < NROWS; r++) begin
      logic [7:0] exp_d;
      rd_addr = VEC[r][14:5]; sen_n = VEC[r][4]; aen_n = VEC[r][3]; init_n = VEC[r][2];
      step();
      exp_d = !VEC[r][1] ? 8'h00 : (VEC[r][0] ? INITW : pat(int'(VEC[r][14:5])));
      chk1("R1/R3/R4 table valid async", qa_valid, VEC[r][1]);
      chk1("R1/R3/R4 table valid sync", qs_valid, VEC[r][1]);
      chk8("R1/R9/R10 table data async", qa_data, exp_d);
      chk8("R1/R8/R10 table data sync", qs_data, exp_d);
    end
    sen_n = 1'b0; aen_n = 1'b0; init_n = 1'b1;

    // R2: address change between edges holds output
    rd_addr = 10'h010; step();
    chk8("R2 first word", qa_data, pat(16));
    rd_addr = 10'h011;
    #1 chk8("R2 held mid-cycle", qa_data, pat(16));
    step(); chk8("R2 next edge", qa_data, pat(17));

    // R4: immediate enable
    aen_n = 1'b1;
    #1 chk1("R4 off without edge", qa_valid, 1'b0);
    chk8("R4/R10 data zero", qa_data, 8'h00);
    aen_n = 1'b0;
    #1 chk8("R4 on without edge", qa_data, pat(17));

    // R3: register loads while disabled
    sen_n = 1'b1; rd_addr = 10'h222; step();
    chk1("R3 disabled", qs_valid, 1'b0);
    sen_n = 1'b0; rd_addr = 10'h223; step();
    chk8("R3 re-enabled shows current", qs_data, pat(12'h223));

    // R7 / R8: pulse between edges
    rd_addr = 10'h020; step();
    init_n = 1'b0;
    #1 chk8("R7 immediate load", qa_data, INITW);
    chk8("R8 pulse not seen", qs_data, pat(32));
    init_n = 1'b1;
    #1 chk8("R7 kept after release", qa_data, INITW);
    chk8("R8 pulse ignored", qs_data, pat(32));
    step();
    chk8("R7 next edge addressed", qa_data, pat(32));
    aen_n = 1'b1; init_n = 1'b0;
    #1 chk1("R7 hidden by aen", qa_valid, 1'b0);
    aen_n = 1'b0;
    #1 chk8("R7 visible when enabled", qa_data, INITW);
    init_n = 1'b1; step();

    // R8: sampled initialize at edge has priority
    init_n = 1'b0; step();
    chk8("R8 init at edge", qs_data, INITW);
    init_n = 1'b1; step();
    chk8("R8 back to address", qs_data, pat(32));

    // R9: live rewrite of an array word
    cfg_write(5, 8'h99);
    rd_addr = 10'h005; step();
    chk8("R9 rewritten word", qs_data, 8'h99);

    // R6: clear and preset
    cfg_write(1024, 8'h00);
    init_n = 1'b0;
    #1 chk8("R6 clear async", qa_data, 8'h00);
    chk1("R6 clear still valid", qa_valid, 1'b1);
    step(); chk8("R6 clear sync", qs_data, 8'h00);
    init_n = 1'b1; step();
    cfg_write(1024, 8'hFF);
    init_n = 1'b0;
    #1 chk8("R6 preset async", qa_data, 8'hFF);
    step(); chk8("R6 preset sync", qs_data, 8'hFF);
    init_n = 1'b1; step();
    chk8("R6 release", qs_data, 8'h99);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule